// File: doc/BRIEF.md
# Programmed I/O Instruction Decoder

This block runs the I/O transfer instructions of a 12-bit processor that has one shared I/O bus. The processor presents an instruction word with an accumulator snapshot. When the word carries the I/O opcode, the decoder takes it and splits out a 6-bit device number and a 3-bit function field. It then drives the device number onto a select bus and fires up to three single-cycle function pulses in a fixed order. While those pulses run, it gathers the device's skip request and any data the device returns. When the sequence ends, it hands the merged accumulator value and the skip decision back to the processor in a one-cycle completion strobe.

Device number zero never reaches the bus. It stands for the processor itself, and its function pulses act on an internal interrupt-enable flag instead. One function turns interrupts on and another turns them off. Turning them on is held back until the instruction after the enabling one has retired. A single shared interrupt line is granted at instruction retirement. The grant produces a one-cycle acknowledge, which tells the processor to jump to address 0000, and it drops the enable.

Devices that treat the function field as an 8-way code instead of independent strobes read the raw field on `fn_code`, which stays valid for the whole time the device is selected.

Top module: `pio_decoder`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high while `busy` is low and `instr[11:9]` equals 3'b110 (octal 6). Any other opcode, or any word offered while `busy` is high, starts nothing and leaves the running sequence unchanged.
- R2: From the cycle after acceptance until completion, `dev_sel` carries `instr[8:3]` and `fn_code` carries `instr[2:0]`. `dev_sel_valid` is high over that span exactly when the device number is non-zero.
- R3: The function pulses go out on `fn_pulse` in this order: `fn_pulse[0]` for `instr[0]`, then `fn_pulse[1]` for `instr[1]`, then `fn_pulse[2]` for `instr[2]`. Each pulse is one cycle wide and is followed by one idle gap cycle. Clear bits are skipped. The first pulse comes in the cycle right after acceptance.
- R4: `done` is high for exactly one cycle, the cycle after the last gap, or the cycle after acceptance if the function field is zero. `busy` is low in the cycle after `done`.
- R5: At `done`, `skip_req` is high exactly when `dev_skip` was high during the `fn_pulse[0]` cycle. `dev_skip` has no effect in any other cycle.
- R6: At `done`, `ac_out` equals the accepted `ac_in` ORed with the `dev_data` present during the `fn_pulse[2]` cycle. `dev_data` has no effect in any other cycle.
- R7: For device zero, `fn_pulse` and `dev_sel_valid` stay low, `skip_req` is low and `ac_out` equals the accepted `ac_in`, with the same pulse and gap timing as any other device. Function bit `instr[0]` sets `int_en` and bit `instr[1]` clears it. When both are set, the clear acts last, so the enable ends up low. Bit `instr[2]` has no effect.
- R8: After an enable, the first `retire` pulse, which belongs to the enabling instruction, grants no interrupt. Only a later `retire` can grant one.
- R9: A `retire` while `int_en` is high, the hold-off is over and `irq` is high produces a one-cycle `int_ack` in the next cycle and clears `int_en`. `int_ack` tells the processor to jump to address 0000. Without `irq`, or with `int_en` low, `retire` produces no `int_ack`.
- R10: A disable clears both the enable and any pending hold-off.
- R11: After reset, `busy`, `done`, `int_en`, `int_ack`, `dev_sel_valid` and `fn_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr | input | 12 | Instruction word, bit 11 is the most significant |
| ac_in | input | 12 | Accumulator value at issue |
| retire | input | 1 | Processor finished an instruction (only while idle) |
| irq | input | 1 | Shared interrupt request line |
| dev_skip | input | 1 | Device skip request |
| dev_data | input | 12 | Device data toward the accumulator |
| busy | output | 1 | Instruction in progress |
| dev_sel | output | 6 | Selected device number |
| dev_sel_valid | output | 1 | External device is selected |
| fn_code | output | 3 | Raw function field |
| fn_pulse | output | 3 | Function strobes, index 0 fires first |
| done | output | 1 | Completion strobe |
| skip_req | output | 1 | Skip the next instruction |
| ac_out | output | 12 | Accumulator result |
| int_en | output | 1 | Interrupt enable flag |
| int_ack | output | 1 | Interrupt granted, jump to 0000 |

## Verification
The assertions assume that the processor raises `retire` only while `busy` is low and never in the same cycle as an accepted instruction. They also assume that devices answer within the pulse cycle. The stimulus respects this by pulsing `retire` only after `done` has come and gone. Device responses are driven in the cycle of the matching strobe. In every other cycle the skip input is held high and the data input carries random noise, so that any sampling outside the pulse windows shows up at the ports.

// File: rtl/pio_decoder.sv
module pio_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [11:0] instr,
  input  logic [11:0] ac_in,
  input  logic        retire,
  input  logic        irq,
  input  logic        dev_skip,
  input  logic [11:0] dev_data,
  output logic        busy,
  output logic [5:0]  dev_sel,
  output logic        dev_sel_valid,
  output logic [2:0]  fn_code,
  output logic [2:0]  fn_pulse,
  output logic        done,
  output logic        skip_req,
  output logic [11:0] ac_out,
  output logic        int_en,
  output logic        int_ack
);

  localparam logic [2:0] IO_OP = 3'o6;

  logic        run, gap, skp, ie, hold, ack;
  logic [2:0]  pend, fn;
  logic [5:0]  dev;
  logic [11:0] acc;
  logic [2:0]  fire;
  logic        self_dev, strobe;

  assign fire     = pend[0] ? 3'b001 : pend[1] ? 3'b010 : pend[2] ? 3'b100 : 3'b000;
  assign self_dev = (dev == 6'd0);
  assign strobe   = run && !gap && (pend != 3'b000);

  assign busy          = run;
  assign dev_sel       = dev;
  assign fn_code       = fn;
  assign dev_sel_valid = run && !self_dev;
  assign fn_pulse      = (strobe && !self_dev) ? fire : 3'b000;
  assign done          = run && !gap && (pend == 3'b000);
  assign skip_req      = skp;
  assign ac_out        = acc;
  assign int_en        = ie;
  assign int_ack       = ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      gap  <= 1'b0;
      pend <= 3'b000;
      fn   <= 3'b000;
      dev  <= 6'd0;
      acc  <= 12'd0;
      skp  <= 1'b0;
      ie   <= 1'b0;
      hold <= 1'b0;
      ack  <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (!run) begin
        if (instr_valid && instr[11:9] == IO_OP) begin
          run  <= 1'b1;
          gap  <= 1'b0;
          pend <= instr[2:0];
          fn   <= instr[2:0];
          dev  <= instr[8:3];
          acc  <= ac_in;
          skp  <= 1'b0;
        end
      end else if (gap) begin
        gap <= 1'b0;
      end else if (pend == 3'b000) begin
        run <= 1'b0;
      end else begin
        pend <= pend & ~fire;
        gap  <= 1'b1;
        if (self_dev) begin
          if (fire[0]) begin
            ie   <= 1'b1;
            hold <= 1'b1;
          end
          if (fire[1]) begin
            ie   <= 1'b0;
            hold <= 1'b0;
          end
        end else begin
          if (fire[0] && dev_skip) skp <= 1'b1;
          if (fire[2]) acc <= acc | dev_data;
        end
      end
      if (retire && !run) begin
        if (hold) begin
          hold <= 1'b0;
        end else if (ie && irq) begin
          ie  <= 1'b0;
          ack <= 1'b1;
        end
      end
    end
  end

  assert_pulse_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fn_pulse));

  assert_pulse_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_pulse != 3'b000) |=> (fn_pulse == 3'b000));

  assert_last_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fn_pulse[2] |=> (fn_pulse == 3'b000) ##1 done);

  assert_order_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fn_pulse[1] |=> ##1 !fn_pulse[0]);

  assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fn_pulse == 3'b000) && !done);

  assert_self_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_sel_valid |-> (fn_pulse == 3'b000));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> !int_en);

  assert_ack_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> $past(retire && irq));

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !int_ack);

endmodule

// File: tb/pio_decoder_test.sv
module pio_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [11:0] instr = 12'd0;
  logic [11:0] ac_in = 12'd0;
  logic        retire = 1'b0;
  logic        irq = 1'b0;
  logic        dev_skip = 1'b0;
  logic [11:0] dev_data = 12'd0;
  logic        busy, dev_sel_valid, done, skip_req, int_en, int_ack;
  logic [5:0]  dev_sel;
  logic [2:0]  fn_code, fn_pulse;
  logic [11:0] ac_out;

  int vectors = 0;
  int miscompares = 0;
  bit m_ie = 1'b0;
  bit m_hold = 1'b0;

  always #5 clk = ~clk;

  pio_decoder uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ac_in(ac_in), .retire(retire), .irq(irq), .dev_skip(dev_skip),
    .dev_data(dev_data), .busy(busy), .dev_sel(dev_sel),
    .dev_sel_valid(dev_sel_valid), .fn_code(fn_code), .fn_pulse(fn_pulse),
    .done(done), .skip_req(skip_req), .ac_out(ac_out), .int_en(int_en),
    .int_ack(int_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_ac(input logic [11:0] w, input logic [11:0] a, input logic [11:0] dat);
    return (w[8:3] != 6'd0 && w[2]) ? (a | dat) : a;
  endfunction

  function automatic logic exp_skip(input logic [11:0] w, input logic sk);
    return (w[8:3] != 6'd0) && w[0] && sk;
  endfunction

  task automatic do_iot(input logic [11:0] w, input logic [11:0] a, input logic sk,
                        input logic [11:0] dat, input bit poke);
    logic [2:0] ep [0:6];
    int n;
    logic [2:0] f;
    logic [5:0] d;
    f = w[2:0];
    d = w[8:3];
    n = 0;
    for (int b = 0; b < 3; b++) begin
      if (f[b]) begin
        ep[n] = 3'(1 << b);
        ep[n+1] = 3'b000;
        n += 2;
      end
    end
    ep[n] = 3'b000;
    if (d == 6'd0) begin
      if (f[0]) begin m_ie = 1'b1; m_hold = 1'b1; end
      if (f[1]) begin m_ie = 1'b0; m_hold = 1'b0; end
    end
    instr_valid = 1'b1;
    instr = w;
    ac_in = a;
    dev_skip = 1'b1;
    dev_data = 12'($urandom);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(busy == 1'b1, "R1 accept", 12'(busy), 12'd1);
    chk(dev_sel == d, "R2 dev_sel", 12'(dev_sel), 12'(d));
    chk(fn_code == f, "R2 fn_code", 12'(fn_code), 12'(f));
    chk(dev_sel_valid == (d != 6'd0), "R2 dev_sel_valid", 12'(dev_sel_valid), 12'(d != 6'd0));
    for (int k = 0; k <= n; k++) begin
      chk(fn_pulse == ((d != 6'd0) ? ep[k] : 3'b000), (d == 6'd0) ? "R7 no pulse" : "R3 pulse order",
          12'(fn_pulse), 12'((d != 6'd0) ? ep[k] : 3'b000));
      chk(done == (k == n), "R4 done timing", 12'(done), 12'(k == n));
      if (k == n) begin
        chk(skip_req == exp_skip(w, sk), "R5 skip", 12'(skip_req), 12'(exp_skip(w, sk)));
        chk(ac_out == exp_ac(w, a, dat), "R6 ac merge", ac_out, exp_ac(w, a, dat));
        chk(int_en == m_ie, "R7 int_en", 12'(int_en), 12'(m_ie));
      end
      dev_skip = fn_pulse[0] ? sk : 1'b1;
      dev_data = fn_pulse[2] ? dat : 12'($urandom);
      instr_valid = poke && (k == 0);
      if (poke && k == 0) instr = 12'o6777;
      @(negedge clk);
    end
    instr_valid = 1'b0;
    chk(busy == 1'b0, "R4 idle after done", 12'(busy), 12'd0);
  endtask

  task automatic do_retire(input logic irq_v);
    bit grant;
    grant = m_ie && !m_hold && irq_v;
    if (m_hold) m_hold = 1'b0;
    else if (grant) m_ie = 1'b0;
    irq = irq_v;
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    irq = 1'b0;
    chk(int_ack == grant, "R8 R9 int_ack", 12'(int_ack), 12'(grant));
    chk(int_en == m_ie, "R9 R10 int_en", 12'(int_en), 12'(m_ie));
    @(negedge clk);
    chk(int_ack == 1'b0, "R9 ack width", 12'(int_ack), 12'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R11 reset busy/done", 12'({busy, done}), 12'd0);
    chk(int_en == 1'b0 && int_ack == 1'b0, "R11 reset int", 12'({int_en, int_ack}), 12'd0);
    chk(fn_pulse == 3'b000 && dev_sel_valid == 1'b0, "R11 reset pulses", 12'(fn_pulse), 12'd0);

    instr_valid = 1'b1;
    instr = 12'o5123;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R1 non-io opcode ignored", 12'(busy), 12'd0);

    do_iot(12'o6457, 12'o1234, 1'b1, 12'o0707, 1'b1);
    do_iot(12'o6450, 12'o4321, 1'b1, 12'o7777, 1'b0);
    do_iot(12'o6774, 12'o0000, 1'b1, 12'o5252, 1'b0);
    do_iot(12'o6101, 12'o0001, 1'b0, 12'o7000, 1'b0);
    do_iot(12'o6012, 12'o0010, 1'b1, 12'o0100, 1'b0);

    do_iot(12'o6001, 12'o0000, 1'b0, 12'o0000, 1'b0);
    do_retire(1'b1);
    do_retire(1'b1);
    do_iot(12'o6001, 12'o0000, 1'b0, 12'o0000, 1'b0);
    do_retire(1'b0);
    do_retire(1'b0);
    do_retire(1'b1);
    do_iot(12'o6003, 12'o0055, 1'b1, 12'o7777, 1'b0);
    do_retire(1'b1);
    do_iot(12'o6001, 12'o0000, 1'b0, 12'o0000, 1'b0);
    do_iot(12'o6002, 12'o0000, 1'b0, 12'o0000, 1'b0);
    do_retire(1'b1);
    do_iot(12'o6007, 12'o0707, 1'b1, 12'o7070, 1'b0);
    do_retire(1'b1);
    do_retire(1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] d;
      logic [2:0] f;
      d = ($urandom % 4 == 0) ? 6'd0 : 6'($urandom);
      f = 3'($urandom);
      do_iot({3'o6, d, f}, 12'($urandom), 1'($urandom), 12'($urandom), ($urandom % 5) == 0);
      if ($urandom % 2 == 0) do_retire(1'($urandom));
    end

    summary();
    $finish;
  end
endmodule